// File: doc/BRIEF.md
# Dual-Modulus Fractional Feedback Divider

This block sits in the feedback path of a fractional-N synthesizer and runs on the fast output clock. It divides that clock down and emits a single-clock feedback pulse at the end of every divide cycle. Every divide cycle lasts either P or P-1 clocks. A phase-accumulator sequencer picks the length of each cycle so that the average division ratio is exactly P - K/D. The pattern repeats every D cycles, and the net timing error over one repetition returns to zero.

Software supplies P, the numerator K and the denominator D together with a one-clock load strobe. A legal setting is staged at once. It replaces the running setting only at the next cycle boundary, so a divide cycle already in progress is never cut short or stretched. When the new setting takes over, the accumulator restarts from zero. The block can count its cycles with either a down counter or an up counter, chosen by a parameter, and both give the same behaviour at the ports.

Top module: `fdiv_frac_divider`

## Requirements
- R1: Every divide cycle lasts P or P-1 clocks of the active setting. `fb_pulse` is high for exactly the last clock of each cycle, and two pulses are never adjacent.
- R2: When K = 0, every divide cycle lasts exactly P clocks.
- R3: When K/D = 1/2, cycle lengths alternate strictly, starting with P: P, P-1, P, P-1, and so on.
- R4: From the boundary where a setting takes effect, cycle i (counted from 0) is short exactly when the running sum of K modulo D wraps on that step. The first cycle is therefore always P long, and any D consecutive cycles together last D·P − K clocks.
- R5: `cyc_short` is 1 during every clock of a P-1 cycle and 0 during every clock of a P cycle.
- R6: A load is captured on the clock edge where `cfg_load` is sampled high. The cycle running at that edge finishes with the old setting. The new setting governs every cycle from the next boundary on, even when the capture edge is itself a boundary.
- R7: A load with P < 3, D = 0 or K ≥ D is ignored, and the running setting and its cycle lengths stay as they were.
- R8: Reset is synchronous and active high. While it is asserted, `fb_pulse` and `cyc_short` are 0 and the setting returns to P = RST_P, K = 0, D = 1. The last edge that samples reset acts as a boundary, so the first pulse appears RST_P − 1 rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | One-clock strobe that stages a new setting |
| cfg_p | input | PW | Integer modulus P (at least 3) |
| cfg_k | input | FW | Fraction numerator K (K < D) |
| cfg_d | input | FW | Fraction denominator D (at least 1) |
| fb_pulse | output | 1 | High in the last clock of each divide cycle |
| cyc_short | output | 1 | High throughout a cycle of length P-1 |

## Verification
A corrupted accumulator or a wrong modulus choice does not stop the pulses. It shows up as a wrong cycle length at the next pulse, so pulse spacing is compared with the expected length one cycle at a time. Some faults keep each cycle length legal but break the D·P − K total. Window sums over every run of D consecutive cycles catch these within one pattern period. A setting applied at the wrong moment alters the interval between the load and the following boundary. That interval is therefore measured directly as well.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

   // smallest modulus that keeps the short cycle at two clocks or more
   localparam int unsigned MIN_P = 3;

   typedef enum logic {
      MOD_LONG  = 1'b0,
      MOD_SHORT = 1'b1
   } mod_e;

endpackage

// File: rtl/fdiv_cfg_stage.sv
module fdiv_cfg_stage
   import fdiv_pkg::*;
#(
   parameter int unsigned PW    = 8,
   parameter int unsigned FW    = 8,
   parameter int unsigned RST_P = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [PW-1:0] ld_p,
   input  logic [FW-1:0] ld_k,
   input  logic [FW-1:0] ld_d,
   input  logic          term,
   output logic [PW-1:0] eff_p,
   output logic [FW-1:0] eff_k,
   output logic [FW-1:0] eff_d,
   output logic          apply,
   output logic [PW-1:0] act_p,
   output logic [FW-1:0] act_k,
   output logic [FW-1:0] act_d
);

   localparam logic [PW-1:0] P_RST = PW'(RST_P);
   localparam logic [PW-1:0] P_MIN = PW'(MIN_P);
   localparam logic [FW-1:0] D_RST = FW'(1);

   logic [PW-1:0] stg_p;
   logic [FW-1:0] stg_k;
   logic [FW-1:0] stg_d;
   logic          pend_q;
   logic          ld_ok;
   logic          take;

   assign ld_ok = (ld_p >= P_MIN) && (ld_d != '0) && (ld_k < ld_d);
   assign take  = load && ld_ok;

   assign eff_p = pend_q ? stg_p : act_p;
   assign eff_k = pend_q ? stg_k : act_k;
   assign eff_d = pend_q ? stg_d : act_d;
   assign apply = pend_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_p  <= P_RST;
         act_k  <= '0;
         act_d  <= D_RST;
         stg_p  <= P_RST;
         stg_k  <= '0;
         stg_d  <= D_RST;
         pend_q <= 1'b0;
      end else begin
         if (term) begin
            act_p <= eff_p;
            act_k <= eff_k;
            act_d <= eff_d;
            if (!take) pend_q <= 1'b0;
         end
         if (take) begin
            stg_p  <= ld_p;
            stg_k  <= ld_k;
            stg_d  <= ld_d;
            pend_q <= 1'b1;
         end
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!term && !rst) |=> $stable({act_p, act_k, act_d})); // R6

   AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (act_p >= P_MIN) && (act_d != '0) && (act_k < act_d)); // R7

endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc
   import fdiv_pkg::*;
#(
   parameter int unsigned FW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          term,
   input  logic          apply,
   input  logic [FW-1:0] k,
   input  logic [FW-1:0] d,
   input  logic [FW-1:0] act_d,
   output mod_e          next_mod,
   output mod_e          cur_mod
);

   localparam int unsigned SW = FW + 1;

   logic [FW-1:0] acc_q;
   logic [SW-1:0] base;
   logic [SW-1:0] sum;
   logic [SW-1:0] wrapped;
   logic          wrap;

   // a new setting restarts the phase from zero
   assign base    = apply ? '0 : {1'b0, acc_q};
   assign sum     = base + {1'b0, k};
   assign wrap    = (sum >= {1'b0, d});
   assign wrapped = wrap ? (sum - {1'b0, d}) : sum;
   assign next_mod = wrap ? MOD_SHORT : MOD_LONG;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         cur_mod <= MOD_LONG;
      end else if (term) begin
         acc_q   <= wrapped[FW-1:0];
         cur_mod <= next_mod;
      end
   end

   AST_ACC_BELOW_D: assert property (@(posedge clk) disable iff (rst)
      acc_q < act_d); // R4

   AST_APPLY_LONG: assert property (@(posedge clk) disable iff (rst)
      (term && apply) |=> (cur_mod == MOD_LONG)); // R4

endmodule

// File: rtl/fdiv_mod_counter.sv
module fdiv_mod_counter #(
   parameter int unsigned PW         = 8,
   parameter int unsigned RST_P      = 8,
   parameter bit          DOWN_COUNT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] next_len,
   output logic          term
);

   localparam logic [PW-1:0] LAST_RST = PW'(RST_P - 1);
   localparam logic [PW-1:0] ONE      = PW'(1);

   generate
      if (DOWN_COUNT) begin : g_down
         logic [PW-1:0] cnt_q;
         assign term = (cnt_q == '0);
         always_ff @(posedge clk) begin
            if (rst)       cnt_q <= LAST_RST;
            else if (term) cnt_q <= next_len - ONE;
            else           cnt_q <= cnt_q - ONE;
         end
      end else begin : g_up
         logic [PW-1:0] cnt_q;
         logic [PW-1:0] lim_q;
         assign term = (cnt_q == lim_q);
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
               lim_q <= LAST_RST;
            end else if (term) begin
               cnt_q <= '0;
               lim_q <= next_len - ONE;
            end else begin
               cnt_q <= cnt_q + ONE;
            end
         end
      end
   endgenerate

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      term |=> !term); // R1

endmodule

// File: rtl/fdiv_frac_divider.sv
module fdiv_frac_divider
   import fdiv_pkg::*;
#(
   parameter int unsigned PW         = 8,
   parameter int unsigned FW         = 8,
   parameter int unsigned RST_P      = 8,
   parameter bit          DOWN_COUNT = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cfg_load,
   input  logic [PW-1:0] cfg_p,
   input  logic [FW-1:0] cfg_k,
   input  logic [FW-1:0] cfg_d,
   output logic          fb_pulse,
   output logic          cyc_short
);

   localparam logic [PW-1:0] ONE = PW'(1);

   generate
      if (PW < 2) begin : g_bad_pw
         $error("PW must be at least 2");
      end
      if (FW < 1) begin : g_bad_fw
         $error("FW must be at least 1");
      end
      if (RST_P < MIN_P || RST_P >= (1 << PW)) begin : g_bad_rst_p
         $error("RST_P must be at least 3 and fit in PW bits");
      end
   endgenerate

   logic          term;
   logic          apply;
   logic [PW-1:0] eff_p;
   logic [FW-1:0] eff_k;
   logic [FW-1:0] eff_d;
   logic [PW-1:0] act_p;
   logic [FW-1:0] act_k;
   logic [FW-1:0] act_d;
   mod_e          next_mod;
   mod_e          cur_mod;
   logic [PW-1:0] next_len;

   fdiv_cfg_stage #(.PW(PW), .FW(FW), .RST_P(RST_P)) u_cfg (
      .clk   (clk),
      .rst   (rst),
      .load  (cfg_load),
      .ld_p  (cfg_p),
      .ld_k  (cfg_k),
      .ld_d  (cfg_d),
      .term  (term),
      .eff_p (eff_p),
      .eff_k (eff_k),
      .eff_d (eff_d),
      .apply (apply),
      .act_p (act_p),
      .act_k (act_k),
      .act_d (act_d)
   );

   fdiv_phase_acc #(.FW(FW)) u_acc (
      .clk      (clk),
      .rst      (rst),
      .term     (term),
      .apply    (apply),
      .k        (eff_k),
      .d        (eff_d),
      .act_d    (act_d),
      .next_mod (next_mod),
      .cur_mod  (cur_mod)
   );

   assign next_len = (next_mod == MOD_SHORT) ? (eff_p - ONE) : eff_p;

   fdiv_mod_counter #(.PW(PW), .RST_P(RST_P), .DOWN_COUNT(DOWN_COUNT)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .next_len (next_len),
      .term     (term)
   );

   assign fb_pulse  = term && !rst;
   assign cyc_short = (cur_mod == MOD_SHORT);

   // independent run-length monitor for the cycle-length property
   logic [PW-1:0] run_len;
   always_ff @(posedge clk) begin
      if (rst || term) run_len <= ONE;
      else             run_len <= run_len + ONE;
   end

   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
      term |-> (run_len == (cyc_short ? (act_p - ONE) : act_p))); // R1

   AST_K0_NO_SHORT: assert property (@(posedge clk) disable iff (rst)
      (act_k == '0) |-> !cyc_short); // R2

   AST_HALF_ALT: assert property (@(posedge clk) disable iff (rst)
      (term && !apply && ({act_k, 1'b0} == {1'b0, act_d}))
         |=> (cyc_short != $past(cyc_short))); // R3

endmodule

// File: tb/tb_fdiv_frac_divider.sv
module tb_fdiv_frac_divider;

   localparam int PW    = 8;
   localparam int FW    = 8;
   localparam int RST_P = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_load = 1'b0;
   logic [PW-1:0] cfg_p = '0;
   logic [FW-1:0] cfg_k = '0;
   logic [FW-1:0] cfg_d = '0;
   logic          fb_pulse;
   logic          cyc_short;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   int meas_q[$];
   bit track = 1'b0;
   int gap = 0;
   int cur_p = RST_P;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   fdiv_frac_divider #(.PW(PW), .FW(FW), .RST_P(RST_P)) dut (
      .clk       (clk),
      .rst       (rst),
      .cfg_load  (cfg_load),
      .cfg_p     (cfg_p),
      .cfg_k     (cfg_k),
      .cfg_d     (cfg_d),
      .fb_pulse  (fb_pulse),
      .cyc_short (cyc_short)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // monitor: pops expected lengths and compares them with measured spacing
   always @(negedge clk) begin
      int e;
      if (rst) begin
         gap = 0;
      end else if (fb_pulse) begin
         if (track) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 unexpected pulse", gap + 1, 0);
            end else begin
               e = exp_q.pop_front();
               chk(gap + 1 == e, "R4 cycle length", gap + 1, e);
               chk(cyc_short == (e == cur_p - 1), "R5 short flag", cyc_short, (e == cur_p - 1));
               meas_q.push_back(gap + 1);
            end
         end
         gap = 0;
      end else begin
         gap++;
      end
   end

   task automatic wait_pulse();
      do @(negedge clk); while (!fb_pulse);
   endtask

   // load (lp,lk,ld); expected pattern follows (mp,mk,md)
   task automatic run_cfg(input int lp, input int lk, input int ld,
                          input int mp, input int mk, input int md,
                          input int n, input int old_len, input string tag);
      int cnt;
      int acc;
      int sum;
      wait_pulse();
      cfg_p = PW'(lp);
      cfg_k = FW'(lk);
      cfg_d = FW'(ld);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      cnt = 1;
      while (!fb_pulse) begin
         @(negedge clk);
         cnt++;
      end
      if (old_len > 0) chk(cnt == old_len, "R6 cycle in progress keeps old length", cnt, old_len);
      #1;
      acc = 0;
      for (int i = 0; i < n; i++) begin
         sum = acc + mk;
         if (sum >= md) begin
            exp_q.push_back(mp - 1);
            acc = sum - md;
         end else begin
            exp_q.push_back(mp);
            acc = sum;
         end
      end
      meas_q.delete();
      cur_p = mp;
      track = 1'b1;
      while (exp_q.size() != 0) @(negedge clk);
      #1;
      track = 1'b0;
      for (int s = 0; s + md <= meas_q.size(); s++) begin
         int tot;
         tot = 0;
         for (int j = 0; j < md; j++) tot += meas_q[s + j];
         chk(tot == md * mp - mk, {tag, " window total"}, tot, md * mp - mk);
      end
   endtask

   initial begin
      int cnt;
      // R8: reset state and first pulse timing
      repeat (3) begin
         @(negedge clk);
         chk(!fb_pulse, "R8 pulse low in reset", fb_pulse, 0);
         chk(!cyc_short, "R8 short low in reset", cyc_short, 0);
      end
      rst = 1'b0;
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!fb_pulse && cnt < 100);
      chk(cnt == RST_P - 1, "R8 first pulse edge count", cnt, RST_P - 1);

      // R2: integer ratio, also checks R6 hold against reset setting
      run_cfg(5, 0, 1, 5, 0, 1, 6, RST_P, "R2");
      // R3: half ratio alternates starting with P
      run_cfg(5, 1, 2, 5, 1, 2, 8, 5, "R3");
      for (int i = 0; i < meas_q.size(); i++)
         chk(meas_q[i] == ((i % 2 == 0) ? 5 : 4), "R3 strict alternation", meas_q[i], (i % 2 == 0) ? 5 : 4);
      // R4: arbitrary fractions
      run_cfg(10, 3, 7, 10, 3, 7, 21, 0, "R4");
      run_cfg(3, 2, 3, 3, 2, 3, 9, 0, "R4");
      run_cfg(12, 13, 16, 12, 13, 16, 32, 0, "R4");
      run_cfg(40, 1, 3, 40, 1, 3, 6, 0, "R4");
      // R1: plain setting then R7 illegal loads leave it untouched
      run_cfg(6, 0, 1, 6, 0, 1, 4, 0, "R1");
      run_cfg(2, 0, 1, 6, 0, 1, 6, 6, "R7 P below 3");
      run_cfg(7, 5, 5, 6, 0, 1, 6, 6, "R7 K not below D");
      run_cfg(7, 0, 0, 6, 0, 1, 6, 6, "R7 D zero");
      summary();
   end

   initial begin
      #(200000 * 20);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
   end

endmodule